// File: doc/BRIEF.md
# Converter-link test pattern generator

This block sits between the converter sample path and the transport layer of a serial converter link and, when asked, puts synthetic sample words in place of the real ones. A 4-bit mode input picks one of these sources: the live samples, a fixed alternating pattern, a whole-word toggle, one of five pseudo-random bit sequences, an incrementing ramp, or a small table of user words. The user table plays either in a loop or once.

The output is registered and advances only on cycles where the sample enable is high. Any change of the mode input restarts the selected source from its initial state, so a receiver-side checker always sees a sequence from its known start. Only one source is active at a time, so the pseudo-random sources share a single shift register. The counter behind the ramp, the alternating patterns and the user-word index is also shared.

Top module: `lane_pattern_gen`

## Requirements
- R1: Mode 0000 and the unused codes 1001 to 1101 copy `din` to `dout`, one clock after an enabled sample.
- R2: Mode 0001 outputs 0x5555 on the first enabled sample after entry, then alternates 0xAAAA and 0x5555.
- R3: Mode 0010 outputs 0xFFFF on the first enabled sample after entry, then alternates 0x0000 and 0xFFFF.
- R4: Modes 0011, 0100, 0101, 0110 and 0111 output bit streams with the polynomials x^31+x^28+1, x^23+x^18+1, x^15+x^14+1, x^9+x^5+1 and x^7+x^6+1. For degree L and middle term T, the L bits of history start as ones. Each new bit is the XOR of the bits L and T places earlier. Every word carries 16 new bits, and the earliest bit goes in bit 15.
- R5: Any change of `mode`, whether or not `smp_en` is high, restarts the selected source: the bit streams reseed to all ones, the ramp starts at 0, the alternating patterns start at their first value, and the user index starts at word 0.
- R6: Mode 1000 outputs 0 on the first enabled sample, adds 1 per enabled sample, and wraps from 0xFFFF to 0x0000.
- R7: Mode 1110 outputs user words 0,1,2,3,0,1,... The user table holds 4 words, and word k is `user_words[16k+15:16k]`.
- R8: Mode 1111 outputs user words 0 to 3 once, then holds 0x0000 until the mode changes.
- R9: `dout` is 0x0000 after reset and keeps its value on every cycle where `smp_en` is low. Source state is kept across such cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_en | input | 1 | Sample enable; one output word per enabled cycle |
| mode | input | 4 | Source select |
| user_words | input | 64 | Four user pattern words, word 0 in the low bits |
| din | input | 16 | Live converter samples |
| dout | output | 16 | Sample word to the transport layer |

## Verification
The bench runs 24 words of each bit stream against a model that builds the sequence from its recurrence. This would expose a wrong tap, a reversed bit order, or a seed that is not all ones. It pauses the enable in the middle of a stream: a design that advanced while paused would skip 16 bits, and one that did not hold its output would change `dout`. It switches modes, including while the enable is low, to catch a source that fails to restart. It drives the ramp through 65536 samples to catch a wrap that saturates or skips. It also plays the one-shot user table to catch a design that loops again or leaves the last word on the output instead of zero.

// File: rtl/lane_pattern_gen.sv
module lane_pattern_gen #(
  parameter int W = 16,
  parameter int UWORDS = 4,
  localparam int UIW = $clog2(UWORDS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  smp_en,
  input  logic [3:0]            mode,
  input  logic [W*UWORDS-1:0]   user_words,
  input  logic [W-1:0]          din,
  output logic [W-1:0]          dout
);

  logic [3:0]   cur_mode;
  logic [W-1:0] cnt, cnt_b, cnt_n, word, pn_word;
  logic [30:0]  pn, pn_b, pn_n;
  logic [4:0]   plen, ptap;
  logic         restart, fb;
  logic [W-1:0] uw [UWORDS];
  logic [UIW-1:0] uidx;

  for (genvar g = 0; g < UWORDS; g++) begin : g_uw
    assign uw[g] = user_words[g*W +: W];
  end

  assign restart = mode != cur_mode;
  assign cnt_b   = restart ? '0 : cnt;
  assign pn_b    = restart ? '1 : pn;
  assign uidx    = cnt_b[UIW-1:0];

  always_comb begin
    plen = 5'd6;
    ptap = 5'd5;
    case (mode)
      4'd3: begin plen = 5'd30; ptap = 5'd27; end
      4'd4: begin plen = 5'd22; ptap = 5'd17; end
      4'd5: begin plen = 5'd14; ptap = 5'd13; end
      4'd6: begin plen = 5'd8;  ptap = 5'd4;  end
      default: ;
    endcase
  end

  always_comb begin
    pn_n    = pn_b;
    pn_word = '0;
    fb      = 1'b0;
    for (int i = 0; i < W; i++) begin
      fb = pn_n[plen] ^ pn_n[ptap];
      pn_n = {pn_n[29:0], fb};
      pn_word[W-1-i] = fb;
    end
  end

  always_comb begin
    cnt_n = cnt_b + 1'b1;
    case (mode)
      4'd1: word = cnt_b[0] ? {W/2{2'b10}} : {W/2{2'b01}};
      4'd2: word = cnt_b[0] ? '0 : '1;
      4'd3, 4'd4, 4'd5, 4'd6, 4'd7: word = pn_word;
      4'd8: word = cnt_b;
      4'd14: word = uw[uidx];
      4'd15: begin
        if (cnt_b < W'(UWORDS)) begin
          word = uw[uidx];
        end else begin
          word  = '0;
          cnt_n = cnt_b;
        end
      end
      default: word = din;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_mode <= 4'd0;
      cnt      <= '0;
      pn       <= '1;
      dout     <= '0;
    end else begin
      cur_mode <= mode;
      if (smp_en) begin
        dout <= word;
        cnt  <= cnt_n;
        pn   <= pn_n;
      end else begin
        cnt  <= cnt_b;
        pn   <= pn_b;
      end
    end
  end

  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en && mode == 4'd0 |=> dout == $past(din)); // R1
  AST_CHECKER_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en && mode == 4'd1 |=> (dout == {W/2{2'b01}} || dout == {W/2{2'b10}})); // R2
  AST_TOGGLE_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en && mode == 4'd2 |=> (dout == '0 || dout == '1)); // R3
  AST_RAMP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en && mode == 4'd8 && cur_mode != 4'd8 |=> dout == '0); // R5
  AST_ONESHOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en && mode == 4'd15 && cur_mode == 4'd15 && cnt == W'(UWORDS) |=> dout == '0); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> $stable(dout)); // R9

endmodule

// File: tb/test_lane_pattern_gen.sv
`timescale 1ns/1ps
module test_lane_pattern_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_en = 1'b0;
  logic [3:0]  mode = 4'd0;
  logic [63:0] user_words = {16'h4444, 16'h3333, 16'h2222, 16'h1111};
  logic [15:0] din = 16'h0;
  logic [15:0] dout;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lane_pattern_gen i_lane_pattern_gen (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .mode(mode),
    .user_words(user_words), .din(din), .dout(dout));

  localparam logic [35:0] TBL [0:13] = '{
    {4'd0,  16'h1234, 16'h1234},
    {4'd0,  16'hBEEF, 16'hBEEF},
    {4'd1,  16'h0000, 16'h5555},
    {4'd1,  16'h0000, 16'hAAAA},
    {4'd1,  16'h0000, 16'h5555},
    {4'd2,  16'h0000, 16'hFFFF},
    {4'd2,  16'h0000, 16'h0000},
    {4'd2,  16'h0000, 16'hFFFF},
    {4'd9,  16'h0F0F, 16'h0F0F},
    {4'd13, 16'h7777, 16'h7777},
    {4'd8,  16'h0000, 16'h0000},
    {4'd8,  16'h0000, 16'h0001},
    {4'd8,  16'h0000, 16'h0002},
    {4'd1,  16'h0000, 16'h5555}
  };

  function automatic string tag_of(input logic [3:0] m);
    case (m)
      4'd1: return "R2";
      4'd2: return "R3";
      4'd8: return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic [3:0] m, input logic [15:0] d);
    @(negedge clk);
    smp_en = en; mode = m; din = d;
    @(posedge clk);
    #1;
  endtask

  task automatic run_pn(input logic [3:0] m, input int L, input int T);
    logic bits [0:1023];
    logic [15:0] exp, last;
    for (int n = 0; n < 1024; n++) bits[n] = (n < L) ? 1'b1 : (bits[n-L] ^ bits[n-T]);
    last = 16'h0;
    for (int k = 0; k < 24; k++) begin
      if (k == 10) begin
        step(1'b0, m, 16'h0);
        check("R9", dout, last);
        step(1'b0, m, 16'h0);
        check("R9", dout, last);
      end
      for (int j = 0; j < 16; j++) exp[15-j] = bits[L + 16*k + j];
      step(1'b1, m, 16'h0);
      check("R4", dout, exp);
      last = exp;
    end
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9", dout, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 14; i++) begin
      step(1'b1, TBL[i][35:32], TBL[i][31:16]);
      check(tag_of(TBL[i][35:32]), dout, TBL[i][15:0]);
    end

    // R9: idle hold, R5: restart on mode change while idle
    step(1'b0, 4'd8, 16'h0);
    check("R9", dout, 16'h5555);
    step(1'b0, 4'd8, 16'h0);
    check("R9", dout, 16'h5555);
    step(1'b1, 4'd8, 16'h0);
    check("R5", dout, 16'h0000);
    step(1'b1, 4'd8, 16'h0);
    step(1'b1, 4'd8, 16'h0);
    step(1'b1, 4'd1, 16'h0);
    step(1'b1, 4'd8, 16'h0);
    check("R5", dout, 16'h0000);

    run_pn(4'd3, 31, 28);
    run_pn(4'd4, 23, 18);
    run_pn(4'd5, 15, 14);
    run_pn(4'd6, 9, 5);
    run_pn(4'd7, 7, 6);
    run_pn(4'd3, 31, 28);

    // R7 continuous user words
    for (int k = 0; k < 10; k++) begin
      step(1'b1, 4'd14, 16'h0);
      check("R7", dout, user_words[16*(k%4) +: 16]);
    end
    // R8 one-shot user words then zero
    for (int k = 0; k < 7; k++) begin
      step(1'b1, 4'd15, 16'h0);
      check("R8", dout, (k < 4) ? user_words[16*k +: 16] : 16'h0000);
    end
    step(1'b0, 4'd15, 16'h0);
    check("R8", dout, 16'h0000);

    // R6 ramp wrap
    for (int k = 0; k < 65536; k++) step(1'b1, 4'd8, 16'h0);
    check("R6", dout, 16'hFFFF);
    step(1'b1, 4'd8, 16'h0);
    check("R6", dout, 16'h0000);
    step(1'b1, 4'd8, 16'h0);
    check("R6", dout, 16'h0001);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule